// File: doc/BRIEF.md
# Two-Way Branch Target Buffer with Test Access

This block is a branch target buffer with 512 entries, arranged as 256 sets of two ways. In normal operation it takes an instruction pointer for lookup. One cycle later it reports whether the pointer hit, which way matched, and the target and line-span flag stored there. A branch update writes an entry. An update that hits rewrites the matching way. An update that misses replaces the way that a per-set least-recently-written flag names as the older one.

A register-style test port can read and write any entry directly. A configuration write sets the test-mode enable and a 9-bit start index. Each later access to the data test strobes moves one entry in or out and then advances the index. Read data comes back one cycle after the access, together with the set's replacement flag. While test mode is on, the port owns the store and branch updates are dropped.

Top module: `btb_2way`

## Requirements
- R1: After reset every entry is invalid, every replacement flag is 0, test mode is off and the test index is 0.
- R2: A lookup is answered in the cycle after `lk_valid`. It hits only when the set addressed by pointer bits 9:2 holds a valid entry whose tag equals pointer bits 18:10 and whose two stored low bits equal pointer bits 1:0. The response gives the matching way (way 0 wins a tie) and that entry's target and span flag.
- R3: An update whose tag and low bits hit a valid entry in its set rewrites that way, and the other way keeps its contents.
- R4: An update that misses writes way 0 when the set's flag is 0 and way 1 when the flag is 1. Every entry write sets the flag to 1 after way 0 is written and to 0 after way 1 is written.
- R5: When a lookup and an update arrive in the same cycle, the lookup sees the contents from before that update.
- R6: `cfg_wr` loads `test_mode` from `cfg_en` and the index from `cfg_index`, visible on the next cycle. A data test strobe in the same cycle as `cfg_wr` is ignored.
- R7: Index bit 0 selects the way and bits 8:1 select the set. A test write stores valid, tag, low bits, span and target. A test read returns those fields and the set's flag on the `dt_r*` outputs, with `dt_rvalid` high, in the next cycle. When both strobes are high, only the write happens.
- R8: Every accepted test read or write advances the index by one, and 0x1FF advances to 0x000.
- R9: While test mode is off, the data test strobes change no entry, leave the index unchanged and raise no `dt_rvalid`.
- R10: While test mode is on, branch updates are ignored.
- R11: A test write moves the replacement flag under the R4 rule. The flag has no write input of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ip | input | 32 | Lookup instruction pointer |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 1 | Way that hit |
| rsp_target | output | 32 | Stored target of the hit entry |
| rsp_span | output | 1 | Stored line-span flag of the hit entry |
| up_valid | input | 1 | Branch update request |
| up_ip | input | 32 | Branch instruction pointer for the update |
| up_target | input | 32 | Target to store |
| up_span | input | 1 | Branch crosses an 8-byte fetch line |
| cfg_wr | input | 1 | Test configuration write strobe |
| cfg_en | input | 1 | Test mode enable value |
| cfg_index | input | 9 | Start index value |
| test_mode | output | 1 | Current test-mode enable |
| cur_index | output | 9 | Current test index |
| dt_wr | input | 1 | Data test write strobe |
| dt_rd | input | 1 | Data test read strobe |
| dt_wvld | input | 1 | Valid bit to write |
| dt_wtag | input | 9 | Tag to write |
| dt_walsb | input | 2 | Low pointer bits to write |
| dt_wspan | input | 1 | Span flag to write |
| dt_wtgt | input | 32 | Target to write |
| dt_rvalid | output | 1 | Read data present |
| dt_rvld | output | 1 | Read valid bit |
| dt_rtag | output | 9 | Read tag |
| dt_ralsb | output | 2 | Read low pointer bits |
| dt_rspan | output | 1 | Read span flag |
| dt_rtgt | output | 32 | Read target |
| dt_rlrw | output | 1 | Replacement flag of the read entry's set |

## Verification
The bench fills all 512 entries through the test port and reads them back across the index wrap. A design that mapped index bit 0 to the set instead of the way, or that failed to wrap, returns another entry's data. Each entry is also looked up with the correct pointer and with its low bits changed. A design that ignored the low bits would report false hits. A fixed sequence of updates to one set covers a miss into each way, a rewrite on hit and an eviction. A swapped flag polarity or a victim chosen on hit would evict the wrong entry. A same-cycle lookup and update, strobes sent while test mode is off, and an update sent while test mode is on would expose bypassing, a leaking disable and a dropped update guard.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned TAG_W = 9;
  localparam int unsigned LSB_W = 2;
  localparam int unsigned TGT_W = 32;
  localparam int unsigned WAYS  = 2;
  localparam int unsigned WAY_W = 1;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [LSB_W-1:0] alsb;
    logic             span;
    logic [TGT_W-1:0] tgt;
  } btb_pay_t;

  typedef struct packed {
    logic     vld;
    btb_pay_t pay;
  } btb_ent_t;
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int unsigned SET_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SET_W-1:0]          w_set,
  input  logic [WAY_W-1:0]          w_way,
  input  btb_ent_t                  w_ent,
  input  logic [SET_W-1:0]          ra_set,
  output btb_ent_t [WAYS-1:0]       ra_ent,
  input  logic [SET_W-1:0]          rb_set,
  output btb_ent_t [WAYS-1:0]       rb_ent,
  output logic                      rb_lrw
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0] lrw_q, lrw_d;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] vld_q, vld_d;
    btb_pay_t        pay_q [SETS];
    logic            hit_we;

    assign hit_we = we && (w_way == WAY_W'(w));

    always_comb begin
      vld_d = vld_q;
      if (hit_we) vld_d[w_set] = w_ent.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit_we) pay_q[w_set] <= w_ent.pay;
    end

    assign ra_ent[w].vld = vld_q[ra_set];
    assign ra_ent[w].pay = pay_q[ra_set];
    assign rb_ent[w].vld = vld_q[rb_set];
    assign rb_ent[w].pay = pay_q[rb_set];
  end

  // flag = 1 when way 0 was the last written, 0 when way 1 was
  always_comb begin
    lrw_d = lrw_q;
    if (we) lrw_d[w_set] = ~w_way[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lrw_q <= '0;
    else        lrw_q <= lrw_d;
  end

  assign rb_lrw = lrw_q[rb_set];
endmodule

// File: rtl/btb_match.sv
module btb_match
  import btb_pkg::*;
(
  input  btb_ent_t [WAYS-1:0] ent,
  input  logic [TAG_W-1:0]    tag,
  input  logic [LSB_W-1:0]    alsb,
  output logic                hit,
  output logic [WAY_W-1:0]    way
);
  logic [WAYS-1:0] m;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign m[w] = ent[w].vld && (ent[w].pay.tag == tag) && (ent[w].pay.alsb == alsb);
  end

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (m[w]) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/btb_test_ctl.sv
module btb_test_ctl #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [IDX_W-1:0] cfg_index,
  input  logic             dt_wr,
  input  logic             dt_rd,
  output logic             test_mode,
  output logic [IDX_W-1:0] cur_index,
  output logic             wr_fire,
  output logic             rd_fire
);
  logic             mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             acc;

  assign acc     = mode_q && !cfg_wr && (dt_wr || dt_rd);
  assign wr_fire = acc && dt_wr;
  assign rd_fire = acc && !dt_wr && dt_rd;

  always_comb begin
    mode_d = mode_q;
    idx_d  = idx_q;
    if (cfg_wr) begin
      mode_d = cfg_en;
      idx_d  = cfg_index;
    end else if (acc) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  assign test_mode = mode_q;
  assign cur_index = idx_q;
endmodule

// File: rtl/btb_2way.sv
module btb_2way
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned IP_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [IP_W-1:0]  lk_ip,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_way,
  output logic [TGT_W-1:0] rsp_target,
  output logic             rsp_span,
  input  logic             up_valid,
  input  logic [IP_W-1:0]  up_ip,
  input  logic [TGT_W-1:0] up_target,
  input  logic             up_span,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [IDX_W-1:0] cfg_index,
  output logic             test_mode,
  output logic [IDX_W-1:0] cur_index,
  input  logic             dt_wr,
  input  logic             dt_rd,
  input  logic             dt_wvld,
  input  logic [TAG_W-1:0] dt_wtag,
  input  logic [LSB_W-1:0] dt_walsb,
  input  logic             dt_wspan,
  input  logic [TGT_W-1:0] dt_wtgt,
  output logic             dt_rvalid,
  output logic             dt_rvld,
  output logic [TAG_W-1:0] dt_rtag,
  output logic [LSB_W-1:0] dt_ralsb,
  output logic             dt_rspan,
  output logic [TGT_W-1:0] dt_rtgt,
  output logic             dt_rlrw
);
  localparam int unsigned SET_W   = IDX_W - 1;
  localparam int unsigned SET_LSB = LSB_W;
  localparam int unsigned TAG_LSB = SET_LSB + SET_W;

  // pointer slices
  logic [SET_W-1:0] lk_set, up_set, t_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_set = lk_ip[SET_LSB +: SET_W];
  assign up_set = up_ip[SET_LSB +: SET_W];
  assign lk_tag = lk_ip[TAG_LSB +: TAG_W];
  assign up_tag = up_ip[TAG_LSB +: TAG_W];

  // test control
  logic wr_fire, rd_fire;
  btb_test_ctl #(.IDX_W(IDX_W)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_en    (cfg_en),
    .cfg_index (cfg_index),
    .dt_wr     (dt_wr),
    .dt_rd     (dt_rd),
    .test_mode (test_mode),
    .cur_index (cur_index),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire)
  );
  assign t_set = cur_index[IDX_W-1:1];

  // storage
  logic                we;
  logic [SET_W-1:0]    w_set, rb_set;
  logic [WAY_W-1:0]    w_way;
  btb_ent_t            w_ent;
  btb_ent_t [WAYS-1:0] ra_ent, rb_ent;
  logic                rb_lrw;

  assign rb_set = test_mode ? t_set : up_set;

  btb_store #(.SET_W(SET_W)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .w_set  (w_set),
    .w_way  (w_way),
    .w_ent  (w_ent),
    .ra_set (lk_set),
    .ra_ent (ra_ent),
    .rb_set (rb_set),
    .rb_ent (rb_ent),
    .rb_lrw (rb_lrw)
  );

  // tag compare for lookup and for update
  logic             lk_hit, up_hit;
  logic [WAY_W-1:0] lk_way, up_way;

  btb_match i_lk_match (
    .ent  (ra_ent),
    .tag  (lk_tag),
    .alsb (lk_ip[LSB_W-1:0]),
    .hit  (lk_hit),
    .way  (lk_way)
  );

  btb_match i_up_match (
    .ent  (rb_ent),
    .tag  (up_tag),
    .alsb (up_ip[LSB_W-1:0]),
    .hit  (up_hit),
    .way  (up_way)
  );

  // write port arbitration: test port in test mode, branch updates otherwise
  logic upd_fire;
  assign upd_fire = up_valid && !test_mode;
  assign we       = wr_fire || upd_fire;

  always_comb begin
    if (wr_fire) begin
      w_set          = t_set;
      w_way          = cur_index[0];
      w_ent.vld      = dt_wvld;
      w_ent.pay.tag  = dt_wtag;
      w_ent.pay.alsb = dt_walsb;
      w_ent.pay.span = dt_wspan;
      w_ent.pay.tgt  = dt_wtgt;
    end else begin
      w_set          = up_set;
      w_way          = up_hit ? up_way : rb_lrw;
      w_ent.vld      = 1'b1;
      w_ent.pay.tag  = up_tag;
      w_ent.pay.alsb = up_ip[LSB_W-1:0];
      w_ent.pay.span = up_span;
      w_ent.pay.tgt  = up_target;
    end
  end

  // lookup response registers
  logic             rv_q, rh_q, rw_q, rs_q;
  logic             rv_d, rh_d, rw_d, rs_d;
  logic [TGT_W-1:0] rt_q, rt_d;
  btb_ent_t         lk_sel;

  assign lk_sel = ra_ent[lk_way];

  always_comb begin
    rv_d = lk_valid;
    rh_d = lk_valid && lk_hit;
    rw_d = rw_q;
    rt_d = rt_q;
    rs_d = rs_q;
    if (lk_valid) begin
      rw_d = lk_way[0];
      rt_d = lk_sel.pay.tgt;
      rs_d = lk_sel.pay.span;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      rw_q <= 1'b0;
      rs_q <= 1'b0;
      rt_q <= '0;
    end else begin
      rv_q <= rv_d;
      rh_q <= rh_d;
      rw_q <= rw_d;
      rs_q <= rs_d;
      rt_q <= rt_d;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_hit    = rh_q;
  assign rsp_way    = rw_q;
  assign rsp_target = rt_q;
  assign rsp_span   = rs_q;

  // test read registers
  btb_ent_t t_sel;
  btb_ent_t tr_q, tr_d;
  logic     tv_q, tv_d, tl_q, tl_d;

  assign t_sel = rb_ent[cur_index[0]];

  always_comb begin
    tv_d = rd_fire;
    tr_d = tr_q;
    tl_d = tl_q;
    if (rd_fire) begin
      tr_d = t_sel;
      tl_d = rb_lrw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= 1'b0;
      tr_q <= '0;
      tl_q <= 1'b0;
    end else begin
      tv_q <= tv_d;
      tr_q <= tr_d;
      tl_q <= tl_d;
    end
  end

  assign dt_rvalid = tv_q;
  assign dt_rvld   = tr_q.vld;
  assign dt_rtag   = tr_q.pay.tag;
  assign dt_ralsb  = tr_q.pay.alsb;
  assign dt_rspan  = tr_q.pay.span;
  assign dt_rtgt   = tr_q.pay.tgt;
  assign dt_rlrw   = tl_q;
endmodule

// File: rtl/btb_2way_chk.sv
module btb_2way_chk #(
  parameter int unsigned IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             cfg_wr,
  input logic             cfg_en,
  input logic [IDX_W-1:0] cfg_index,
  input logic             test_mode,
  input logic [IDX_W-1:0] cur_index,
  input logic             dt_wr,
  input logic             dt_rd,
  input logic             dt_rvalid
);
  AST_LK_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R2
  AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (test_mode == $past(cfg_en)) && (cur_index == $past(cfg_index))); // R6
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !cfg_wr && (dt_wr || dt_rd)) |=> cur_index == IDX_W'($past(cur_index) + 1'b1)); // R8
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !cfg_wr) |=> $stable(cur_index)); // R9
  AST_RD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !cfg_wr && dt_rd && !dt_wr) |=> dt_rvalid); // R7
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> !dt_rvalid); // R9
endmodule

bind btb_2way btb_2way_chk #(.IDX_W(IDX_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .cfg_wr    (cfg_wr),
  .cfg_en    (cfg_en),
  .cfg_index (cfg_index),
  .test_mode (test_mode),
  .cur_index (cur_index),
  .dt_wr     (dt_wr),
  .dt_rd     (dt_rd),
  .dt_rvalid (dt_rvalid)
);

// File: tb/test_btb_2way.sv
module test_btb_2way;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ip = '0;
  logic        rsp_valid, rsp_hit, rsp_way, rsp_span;
  logic [31:0] rsp_target;
  logic        up_valid = 1'b0;
  logic [31:0] up_ip = '0;
  logic [31:0] up_target = '0;
  logic        up_span = 1'b0;
  logic        cfg_wr = 1'b0, cfg_en = 1'b0;
  logic [8:0]  cfg_index = '0;
  logic        test_mode;
  logic [8:0]  cur_index;
  logic        dt_wr = 1'b0, dt_rd = 1'b0, dt_wvld = 1'b0, dt_wspan = 1'b0;
  logic [8:0]  dt_wtag = '0;
  logic [1:0]  dt_walsb = '0;
  logic [31:0] dt_wtgt = '0;
  logic        dt_rvalid, dt_rvld, dt_rspan, dt_rlrw;
  logic [8:0]  dt_rtag;
  logic [1:0]  dt_ralsb;
  logic [31:0] dt_rtgt;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_2way i_btb_2way (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ip(lk_ip),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_target(rsp_target), .rsp_span(rsp_span),
    .up_valid(up_valid), .up_ip(up_ip), .up_target(up_target), .up_span(up_span),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_index(cfg_index),
    .test_mode(test_mode), .cur_index(cur_index),
    .dt_wr(dt_wr), .dt_rd(dt_rd), .dt_wvld(dt_wvld), .dt_wtag(dt_wtag),
    .dt_walsb(dt_walsb), .dt_wspan(dt_wspan), .dt_wtgt(dt_wtgt),
    .dt_rvalid(dt_rvalid), .dt_rvld(dt_rvld), .dt_rtag(dt_rtag),
    .dt_ralsb(dt_ralsb), .dt_rspan(dt_rspan), .dt_rtgt(dt_rtgt), .dt_rlrw(dt_rlrw)
  );

  // pattern for entry i
  function automatic logic       p_vld (int i); return (i % 3) != 0; endfunction
  function automatic logic [8:0] p_tag (int i); return 9'(i * 7 + 3); endfunction
  function automatic logic [1:0] p_lsb (int i); return 2'(i); endfunction
  function automatic logic       p_spn (int i); return 1'((i >> 2) & 1); endfunction
  function automatic logic [31:0] p_tgt(int i); return 32'h5A00_0000 ^ 32'(i * 32'h0001_0103); endfunction
  function automatic logic [31:0] mk_ip(logic [8:0] tag, logic [7:0] set, logic [1:0] lsb);
    return {13'h0, tag, set, lsb};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic [8:0] idx);
    cfg_wr = 1'b1; cfg_en = en; cfg_index = idx;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic twrite(input logic v, input logic [8:0] t, input logic [1:0] l,
                        input logic s, input logic [31:0] g);
    dt_wr = 1'b1; dt_wvld = v; dt_wtag = t; dt_walsb = l; dt_wspan = s; dt_wtgt = g;
    @(negedge clk);
    dt_wr = 1'b0;
  endtask

  task automatic tread(output logic [46:0] r);
    dt_rd = 1'b1;
    @(negedge clk);
    dt_rd = 1'b0;
    r = {dt_rvalid, dt_rvld, dt_rtag, dt_ralsb, dt_rspan, dt_rtgt, dt_rlrw};
  endtask

  task automatic lookup(input logic [31:0] ip, output logic [35:0] r);
    lk_valid = 1'b1; lk_ip = ip;
    @(negedge clk);
    lk_valid = 1'b0;
    r = {rsp_valid, rsp_hit, rsp_way, rsp_span, rsp_target};
  endtask

  task automatic update(input logic [31:0] ip, input logic [31:0] tgt, input logic spn);
    up_valid = 1'b1; up_ip = ip; up_target = tgt; up_span = spn;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  function automatic logic [46:0] exp_rd(int i, logic lrw);
    return {1'b1, p_vld(i), p_tag(i), p_lsb(i), p_spn(i), p_tgt(i), lrw};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [46:0] rd;
    logic [35:0] lr;
    logic [31:0] ipa, ipb, ipc, ipd, ipe;

    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mode/index", {test_mode, cur_index}, 10'h000);

    // R9: strobes while disabled
    twrite(1'b1, 9'h1AA, 2'b11, 1'b1, 32'hDEAD_BEEF);
    tread(rd);
    check("R9 index frozen while disabled", cur_index, 9'h000);
    check("R9 no read response while disabled", rd[46], 1'b0);

    // R6 + R7 + R8: fill all entries through the test port
    cfg(1'b1, 9'h000);
    check("R6 cfg loads enable and index", {test_mode, cur_index}, {1'b1, 9'h000});
    for (int i = 0; i < 512; i++) twrite(p_vld(i), p_tag(i), p_lsb(i), p_spn(i), p_tgt(i));
    check("R8 index wrapped after 512 writes", cur_index, 9'h000);
    for (int i = 0; i < 512; i++) begin
      tread(rd);
      check($sformatf("R7 readback entry %0d", i), rd, exp_rd(i, 1'b0));
    end

    // R8: wrap over 0x1FF
    cfg(1'b1, 9'h1FE);
    tread(rd); check("R8 read 0x1FE", rd, exp_rd(510, 1'b0));
    tread(rd); check("R8 read 0x1FF", rd, exp_rd(511, 1'b0));
    tread(rd); check("R8 read 0x000 after wrap", rd, exp_rd(0, 1'b0));
    check("R8 index after wrap", cur_index, 9'h001);

    // R6: strobe with cfg_wr is ignored
    cfg_wr = 1'b1; cfg_en = 1'b1; cfg_index = 9'h020; dt_wr = 1'b1;
    dt_wvld = 1'b1; dt_wtag = 9'h0F0; dt_walsb = 2'b00; dt_wspan = 1'b0; dt_wtgt = 32'h1;
    @(negedge clk);
    cfg_wr = 1'b0; dt_wr = 1'b0;
    check("R6 index from cfg despite strobe", cur_index, 9'h020);
    tread(rd); check("R6 entry 0x020 untouched", rd, exp_rd(32, 1'b0));

    // R9: disabled write leaves entry intact
    cfg(1'b0, 9'h040);
    twrite(1'b1, 9'h0F0, 2'b00, 1'b0, 32'h1234_5678);
    check("R9 index frozen after disabled write", cur_index, 9'h040);
    cfg(1'b1, 9'h040);
    tread(rd); check("R9 entry 0x040 unchanged", rd, exp_rd(64, 1'b0));

    // R11: test write to way 0 flips the set's flag to 1
    cfg(1'b1, 9'h00A);
    twrite(p_vld(10), p_tag(10), p_lsb(10), p_spn(10), p_tgt(10));
    cfg(1'b1, 9'h00A);
    tread(rd); check("R11 flag after way0 test write", rd, exp_rd(10, 1'b1));
    tread(rd); check("R11 flag shared by way1 of same set", rd, exp_rd(11, 1'b1));

    // R7: both strobes -> write only, no read response
    cfg(1'b1, 9'h00C);
    dt_rd = 1'b1;
    twrite(p_vld(12), p_tag(12), p_lsb(12), p_spn(12), p_tgt(12));
    dt_rd = 1'b0;
    check("R7 write wins over read", {dt_rvalid, cur_index}, {1'b0, 9'h00D});

    // R2: lookup sweep
    cfg(1'b0, 9'h000);
    for (int i = 0; i < 512; i++) begin
      lookup(mk_ip(p_tag(i), 8'(i >> 1), p_lsb(i)), lr);
      if (p_vld(i))
        check($sformatf("R2 lookup hit %0d", i), lr, {1'b1, 1'b1, 1'(i & 1), p_spn(i), p_tgt(i)});
      else
        check($sformatf("R2 lookup miss invalid %0d", i), lr[35:34], 2'b10);
      lookup(mk_ip(p_tag(i), 8'(i >> 1), p_lsb(i) ^ 2'b10), lr);
      check($sformatf("R2 low-bit mismatch misses %0d", i), lr[35:34], 2'b10);
    end
    lookup(mk_ip(p_tag(4) ^ 9'h100, 8'd2, p_lsb(4)), lr);
    check("R2 tag mismatch misses", lr[35:34], 2'b10);

    // R1: reset clears everything
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode/index after reset", {test_mode, cur_index}, 10'h000);
    lookup(mk_ip(p_tag(4), 8'd2, p_lsb(4)), lr);
    check("R1 previously valid entry misses", lr[35:34], 2'b10);
    cfg(1'b1, 9'h014);
    tread(rd); check("R1 entry invalid, flag 0", {rd[46:45], rd[0]}, 3'b100);
    tread(rd); check("R1 entry invalid way1", {rd[46:45], rd[0]}, 3'b100);

    // R10: updates ignored in test mode
    update(mk_ip(9'h155, 8'd3, 2'b00), 32'hCAFE_0000, 1'b0);
    cfg(1'b0, 9'h000);
    lookup(mk_ip(9'h155, 8'd3, 2'b00), lr);
    check("R10 update in test mode dropped", lr[35:34], 2'b10);

    // R3/R4: replacement sequence in set 0x40
    ipa = mk_ip(9'h011, 8'h40, 2'b01);
    ipb = mk_ip(9'h022, 8'h40, 2'b01);
    ipc = mk_ip(9'h033, 8'h40, 2'b01);
    ipd = mk_ip(9'h044, 8'h40, 2'b01);
    update(ipa, 32'hA0A0_0001, 1'b1);
    lookup(ipa, lr); check("R4 first miss fills way0", lr, {3'b110, 1'b1, 32'hA0A0_0001});
    update(ipb, 32'hB0B0_0002, 1'b0);
    lookup(ipb, lr); check("R4 second miss fills way1", lr, {3'b111, 1'b0, 32'hB0B0_0002});
    update(ipc, 32'hC0C0_0003, 1'b0);
    lookup(ipc, lr); check("R4 third miss evicts way0", lr, {3'b110, 1'b0, 32'hC0C0_0003});
    lookup(ipa, lr); check("R4 evicted entry misses", lr[35:34], 2'b10);
    update(ipb, 32'hB1B1_0004, 1'b1);
    lookup(ipb, lr); check("R3 hit rewrites matching way", lr, {3'b111, 1'b1, 32'hB1B1_0004});
    lookup(ipc, lr); check("R3 other way kept", lr, {3'b110, 1'b0, 32'hC0C0_0003});
    update(ipd, 32'hD0D0_0005, 1'b0);
    lookup(ipd, lr); check("R4 victim follows flag after hit write", lr, {3'b110, 1'b0, 32'hD0D0_0005});
    lookup(ipc, lr); check("R4 way0 entry replaced", lr[35:34], 2'b10);
    lookup(ipb, lr); check("R4 way1 entry survives", lr, {3'b111, 1'b1, 32'hB1B1_0004});
    cfg(1'b1, 9'h080);
    tread(rd); check("R4 flag 1 after way0 write", {rd[46:45], rd[0]}, 3'b111);
    cfg(1'b0, 9'h000);

    // R5: same-cycle lookup and update
    ipe = mk_ip(9'h077, 8'h41, 2'b10);
    lk_valid = 1'b1; lk_ip = ipe;
    up_valid = 1'b1; up_ip = ipe; up_target = 32'hE0E0_0006; up_span = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check("R5 same-cycle lookup sees old data", {rsp_valid, rsp_hit}, 2'b10);
    lookup(ipe, lr); check("R5 next lookup sees update", lr, {3'b110, 1'b1, 32'hE0E0_0006});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule